// File: doc/BRIEF.md
# Command and Response Queue Pair

This block holds the two queues that sit between software and the transfer engine of a programmed-I/O I3C host controller. Software builds each command descriptor by writing 32-bit words to a single command port. The descriptor is two words long in version 1 mode and four words long in version 2 mode. The back end sees a command only once its last word has been written, and then takes it as one wide word. Going the other way, the back end pushes 32-bit responses, and software drains them by reading the response port.

The block has a threshold register that software can read and write. Two of its fields set when the command-ready level and the response-ready level are raised. Two more fields, used by the in-band interrupt path, are only stored and read back. A read-only status word reports how many command slots are free and how many responses are waiting. A size word reports the queue depth. Two error pulses flag a programming mistake: a command word written with no slot free, and a response read with nothing queued.

Top module: `hci_cmd_resp_queues`

## Requirements
- R1: After reset, the free-slot count equals DEPTH, the response level is 0, the threshold register reads 0, command-ready is 1, response-ready is 0 and the back end sees no command.
- R2: The register offsets are fixed: command port 0x00 (write), response port 0x04 (read), threshold register 0x10 (read/write, all 32 bits read back as written) and size word 0x18. The threshold fields are: bits 7:0 command free-slot threshold, bits 15:8 response threshold, bits 23:16 and 31:24 stored only. A register read returns its data on reg_rdata in the cycle after reg_rd_en.
- R3: A descriptor is WORDS words (2 when VERSION is 1, 4 when VERSION is 2), written in order to offset 0x00. be_cmd_valid stays low until the last word is written. Word k of the descriptor appears on be_cmd_data bits 32k+31:32k. Commands leave in the order they were written.
- R4: A partly written descriptor already occupies a slot, so the free-slot count falls by one when its first word is written.
- R5: cmd_ready_o is 1 exactly when the free-slot count is at least the command threshold, with a threshold of 0 taken as 1.
- R6: resp_ready_o is 1 exactly when the response level is at least the response threshold, with a threshold of 0 taken as 1.
- R7: Writing the first word of a descriptor when no slot is free drops the word, leaves the queue unchanged and pulses cmd_ovf_o for one cycle, in the cycle after the write.
- R8: Reading the response port with no response queued returns 0, leaves the queue unchanged and pulses resp_udf_o for one cycle, in the cycle after the read.
- R9: Responses are returned in the order they were pushed. be_resp_full is 1 when DEPTH responses are held, and a push made while it is high is ignored.
- R10: The status word at 0x38 holds the free-slot count in bits 8:0, the response level in bits 18:10 and zeros elsewhere (bits 28:20 are a reserved IBI level and read 0). The size word at 0x18 holds DEPTH in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd_en |
| cmd_ready_o | output | 1 | Enough free command slots |
| resp_ready_o | output | 1 | Enough queued responses |
| cmd_ovf_o | output | 1 | Command overflow pulse |
| resp_udf_o | output | 1 | Response underflow pulse |
| be_cmd_valid | output | 1 | A complete command is available |
| be_cmd_pop | input | 1 | Back end takes the head command |
| be_cmd_data | output | 32*WORDS | Head command, word 0 in the low bits |
| be_resp_push | input | 1 | Back end pushes a response |
| be_resp_data | input | 32 | Response word |
| be_resp_full | output | 1 | Response queue holds DEPTH entries |

## Verification
Register read data and the two error pulses come from registers. They are due in the cycle after the access, and they are sampled at the falling edge that follows the capturing rising edge. The ready levels, the counts in the status word, be_cmd_valid and be_resp_full are decoded from the queue state. They change right after the rising edge that takes a write, pop, push or read, and are also sampled at the next falling edge. The back-end command data is checked before the pop is issued, so each command is seen while it is still at the head of the queue.

// File: rtl/hci_q_pkg.sv
// Shared definitions for the command/response queue pair: register
// offsets and the threshold rule. Assumes byte offsets on an 8-bit address.
package hci_q_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_RSP  = 8'h04;
    localparam logic [7:0] OFS_THR  = 8'h10;
    localparam logic [7:0] OFS_SIZE = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h38;

    // Threshold as compared against a 9-bit level; zero acts as one.
    function automatic logic [8:0] thr_floor(input logic [7:0] t);
        return (t == 8'd0) ? 9'd1 : {1'b0, t};
    endfunction
endpackage

// File: rtl/hci_cmd_fifo.sv
// Command queue: collects WORDS-word descriptors from one write port and
// hands out whole descriptors. Assumes DEPTH >= 2 and DEPTH <= 255.
// A partly built descriptor holds its slot. A first word with no slot free is dropped.
module hci_cmd_fifo #(
    parameter int DEPTH = 4,
    parameter int WORDS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic               pop,
    output logic               cmd_valid,
    output logic [WORDS*32-1:0] cmd_data,
    output logic [8:0]         free_slots,
    output logic               ovf
);
    localparam int PW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int XW  = (WORDS > 2) ? 2 : 1;
    localparam logic [XW-1:0] LAST_W = XW'(WORDS - 1);
    localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

    logic [WORDS*32-1:0] mem [DEPTH];
    logic [PW-1:0] wr_slot, rd_slot;
    logic [XW-1:0] widx;
    logic [CW-1:0] done_cnt;
    logic [CW-1:0] used;
    logic accept, commit, take;

    // Slots in use: finished descriptors plus one under construction.
    always_comb begin
        used   = done_cnt + CW'(widx != '0);
        accept = wr_en && ((widx != '0) || (used < CW'(DEPTH)));
        commit = accept && (widx == LAST_W);
        take   = pop && (done_cnt != '0);
    end

    // Store each accepted word in its place within the current slot.
    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_slot][32*widx +: 32] <= wr_data;
    end

    // Pointer, word index, count and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot  <= '0;
            rd_slot  <= '0;
            widx     <= '0;
            done_cnt <= '0;
            ovf      <= 1'b0;
        end else begin
            ovf <= wr_en && !accept;
            if (accept)
                widx <= commit ? '0 : widx + 1'b1;
            if (commit)
                wr_slot <= (wr_slot == LAST_P) ? '0 : wr_slot + 1'b1;
            if (take)
                rd_slot <= (rd_slot == LAST_P) ? '0 : rd_slot + 1'b1;
            done_cnt <= done_cnt + CW'(commit) - CW'(take);
        end
    end

    assign cmd_valid  = (done_cnt != '0);
    assign cmd_data   = mem[rd_slot];
    assign free_slots = 9'(DEPTH) - 9'(used);
endmodule

// File: rtl/hci_rsp_fifo.sv
// Response queue: the back end pushes 32-bit words and software pops them.
// Assumes DEPTH >= 2. A push while full is ignored, and a pop while empty does nothing.
module hci_rsp_fifo #(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] head,
    output logic        full,
    output logic [8:0]  level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

    logic [31:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic do_push, do_pop;

    // Gate push on room and pop on content.
    always_comb begin
        do_push = push && (cnt != CW'(DEPTH));
        do_pop  = pop && (cnt != '0);
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= push_data;
    end

    // Pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push)
                wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
            if (do_pop)
                rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign level = 9'(cnt);
endmodule

// File: rtl/hci_cmd_resp_queues.sv
// Top of the command/response queue pair: register decode, the threshold
// register, readiness levels and error pulses. Assumes a single-cycle
// register strobe. Read data is registered.
module hci_cmd_resp_queues
    import hci_q_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int VERSION = 1,
    localparam int WORDS  = (VERSION >= 2) ? 4 : 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                cmd_ready_o,
    output logic                resp_ready_o,
    output logic                cmd_ovf_o,
    output logic                resp_udf_o,
    output logic                be_cmd_valid,
    input  logic                be_cmd_pop,
    output logic [WORDS*32-1:0] be_cmd_data,
    input  logic                be_resp_push,
    input  logic [31:0]         be_resp_data,
    output logic                be_resp_full
);
    logic [31:0] thr_q;
    logic [8:0]  free_slots, rsp_level;
    logic [31:0] rsp_head;
    logic        cmd_wr, rsp_rd;

    // Port strobes.
    assign cmd_wr = reg_wr_en && (reg_addr == OFS_CMD);
    assign rsp_rd = reg_rd_en && (reg_addr == OFS_RSP);

    hci_cmd_fifo #(.DEPTH(DEPTH), .WORDS(WORDS)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wr_data(reg_wdata),
        .pop(be_cmd_pop), .cmd_valid(be_cmd_valid), .cmd_data(be_cmd_data),
        .free_slots(free_slots), .ovf(cmd_ovf_o)
    );

    hci_rsp_fifo #(.DEPTH(DEPTH)) u_rsp (
        .clk(clk), .rst_n(rst_n), .push(be_resp_push), .push_data(be_resp_data),
        .pop(rsp_rd), .head(rsp_head), .full(be_resp_full), .level(rsp_level)
    );

    // Threshold register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= '0;
        else if (reg_wr_en && reg_addr == OFS_THR)
            thr_q <= reg_wdata;
    end

    // Registered read data and underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            resp_udf_o <= 1'b0;
        end else begin
            resp_udf_o <= rsp_rd && (rsp_level == 9'd0);
            if (reg_rd_en) begin
                case (reg_addr)
                    OFS_RSP:  reg_rdata <= (rsp_level != 9'd0) ? rsp_head : '0;
                    OFS_THR:  reg_rdata <= thr_q;
                    OFS_SIZE: reg_rdata <= {24'd0, 8'(DEPTH)};
                    OFS_STAT: reg_rdata <= {13'd0, rsp_level, 1'b0, free_slots};
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end

    // Readiness levels against the programmed thresholds.
    assign cmd_ready_o  = (free_slots >= thr_floor(thr_q[7:0]));
    assign resp_ready_o = (rsp_level >= thr_floor(thr_q[15:8]));
endmodule

// File: rtl/hci_cmd_resp_queues_chk.sv
// Property checker for the queue pair, bound into every instance of the top.
module hci_cmd_resp_queues_chk
    import hci_q_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        cmd_ready_o,
    input logic        resp_ready_o,
    input logic        cmd_ovf_o,
    input logic        resp_udf_o,
    input logic        be_resp_full,
    input logic [8:0]  free_slots,
    input logic [8:0]  rsp_level
);
    AST_CMD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ovf_o |-> $past(reg_wr_en && reg_addr == OFS_CMD && free_slots == 9'd0)); // R7
    AST_OVF_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ovf_o |-> free_slots >= $past(free_slots)); // R7
    AST_RESP_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        resp_udf_o |-> $past(reg_rd_en && reg_addr == OFS_RSP && rsp_level == 9'd0)); // R8
    AST_UDF_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_udf_o |-> reg_rdata == 32'd0); // R8
    AST_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> free_slots != 9'd0); // R5
    AST_RESP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready_o |-> rsp_level != 9'd0); // R6
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_level <= 9'(DEPTH)) && (free_slots <= 9'(DEPTH))); // R10
    AST_RESP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        be_resp_full |-> rsp_level == 9'(DEPTH)); // R9
endmodule

bind hci_cmd_resp_queues hci_cmd_resp_queues_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cmd_ready_o(cmd_ready_o),
    .resp_ready_o(resp_ready_o), .cmd_ovf_o(cmd_ovf_o), .resp_udf_o(resp_udf_o),
    .be_resp_full(be_resp_full), .free_slots(free_slots), .rsp_level(rsp_level)
);

// File: tb/tb_hci_cmd_resp_queues.sv
// Bench for the queue pair: a vector table followed by directed corner tests.
module tb_hci_cmd_resp_queues;
    localparam int DEPTH = 4;
    localparam int VERSION = 1;
    localparam int WORDS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic cmd_ready_o, resp_ready_o, cmd_ovf_o, resp_udf_o;
    logic be_cmd_valid, be_cmd_pop = 1'b0;
    logic [WORDS*32-1:0] be_cmd_data;
    logic be_resp_push = 1'b0;
    logic [31:0] be_resp_data = '0;
    logic be_resp_full;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hci_cmd_resp_queues #(.DEPTH(DEPTH), .VERSION(VERSION)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_ready_o(cmd_ready_o), .resp_ready_o(resp_ready_o),
        .cmd_ovf_o(cmd_ovf_o), .resp_udf_o(resp_udf_o),
        .be_cmd_valid(be_cmd_valid), .be_cmd_pop(be_cmd_pop), .be_cmd_data(be_cmd_data),
        .be_resp_push(be_resp_push), .be_resp_data(be_resp_data), .be_resp_full(be_resp_full)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); be_resp_push = 1'b1; be_resp_data = d;
        @(negedge clk); be_resp_push = 1'b0;
    endtask

    task automatic popc(output logic [WORDS*32-1:0] d);
        @(negedge clk); d = be_cmd_data; be_cmd_pop = 1'b1;
        @(negedge clk); be_cmd_pop = 1'b0;
    endtask

    // Vector: op(2) addr(8) data(32) expected(32). op 0 read, 1 write, 2 pop command, 3 push response.
    localparam int NV = 17;
    localparam logic [73:0] VEC [NV] = '{
        {2'd0, 8'h38, 32'h0,         32'h0000_0004},  // R1 R10 reset status
        {2'd0, 8'h18, 32'h0,         32'h0000_0004},  // R10 size word
        {2'd1, 8'h10, 32'hAABB_0102, 32'h0},          // R2 thresholds
        {2'd0, 8'h10, 32'h0,         32'hAABB_0102},  // R2 readback
        {2'd1, 8'h00, 32'hC000_0001, 32'h0},          // R3 word 0
        {2'd0, 8'h38, 32'h0,         32'h0000_0003},  // R4 partial holds slot
        {2'd1, 8'h00, 32'hC000_0002, 32'h0},          // R3 word 1
        {2'd0, 8'h38, 32'h0,         32'h0000_0003},  // R4 still one slot
        {2'd2, 8'h00, 32'h0,         32'hC000_0001},  // R3 head word 0
        {2'd0, 8'h38, 32'h0,         32'h0000_0004},  // R10 freed
        {2'd3, 8'h00, 32'h5000_0001, 32'h0},          // R9 push
        {2'd3, 8'h00, 32'h5000_0002, 32'h0},          // R9 push
        {2'd0, 8'h38, 32'h0,         32'h0000_0804},  // R10 level field
        {2'd0, 8'h04, 32'h0,         32'h5000_0001},  // R9 order
        {2'd0, 8'h04, 32'h0,         32'h5000_0002},  // R9 order
        {2'd0, 8'h04, 32'h0,         32'h0000_0000},  // R8 empty read
        {2'd0, 8'h38, 32'h0,         32'h0000_0004}   // R8 unchanged
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [WORDS*32-1:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 cmd_ready", 64'(cmd_ready_o), 64'd1);
        check("R1 resp_ready", 64'(resp_ready_o), 64'd0);
        check("R1 be_cmd_valid", 64'(be_cmd_valid), 64'd0);
        check("R1 be_resp_full", 64'(be_resp_full), 64'd0);
        rd(8'h10, r); check("R1 threshold reg", 64'(r), 64'd0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][73:72])
                2'd0: begin rd(VEC[i][71:64], r); check($sformatf("vec%0d read", i), 64'(r), 64'(VEC[i][31:0])); end
                2'd1: wr(VEC[i][71:64], VEC[i][63:32]);
                2'd2: begin popc(c); check($sformatf("vec%0d R3 pop", i), 64'(c[31:0]), 64'(VEC[i][31:0])); end
                default: push(VEC[i][63:32]);
            endcase
        end

        // R3 descriptor visible only after its last word
        wr(8'h00, 32'h1111_0000);
        check("R3 hidden while partial", 64'(be_cmd_valid), 64'd0);
        wr(8'h00, 32'h1111_0001);
        check("R3 visible when complete", 64'(be_cmd_valid), 64'd1);
        check("R3 word layout", 64'(be_cmd_data), 64'h1111_0001_1111_0000);
        wr(8'h00, 32'h2222_0000); wr(8'h00, 32'h2222_0001);
        check("R5 two free, thr 2", 64'(cmd_ready_o), 64'd1);
        wr(8'h00, 32'h3333_0000); wr(8'h00, 32'h3333_0001);
        check("R5 one free, thr 2", 64'(cmd_ready_o), 64'd0);
        wr(8'h00, 32'h4444_0000);
        rd(8'h38, r); check("R4 last slot taken by partial", 64'(r[8:0]), 64'd0);
        wr(8'h00, 32'h4444_0001);
        // R7 overflow on first word with no free slot
        wr(8'h00, 32'h5555_0000);
        check("R7 overflow pulse", 64'(cmd_ovf_o), 64'd1);
        @(negedge clk);
        check("R7 pulse one cycle", 64'(cmd_ovf_o), 64'd0);
        rd(8'h38, r); check("R7 queue unchanged", 64'(r[8:0]), 64'd0);
        popc(c); check("R3 order 1", 64'(c), 64'h1111_0001_1111_0000);
        popc(c); check("R3 order 2", 64'(c), 64'h2222_0001_2222_0000);
        popc(c); check("R3 order 3", 64'(c), 64'h3333_0001_3333_0000);
        popc(c); check("R7 last kept intact", 64'(c), 64'h4444_0001_4444_0000);
        check("R3 queue drained", 64'(be_cmd_valid), 64'd0);

        // R6 response threshold 3
        wr(8'h10, 32'h0000_0300);
        push(32'hA1); push(32'hA2);
        check("R6 two below thr 3", 64'(resp_ready_o), 64'd0);
        push(32'hA3);
        check("R6 three meets thr 3", 64'(resp_ready_o), 64'd1);
        push(32'hA4);
        check("R9 full flag", 64'(be_resp_full), 64'd1);
        push(32'hA5);
        rd(8'h04, r); check("R9 first", 64'(r), 64'hA1);
        rd(8'h04, r); check("R9 second", 64'(r), 64'hA2);
        rd(8'h04, r); check("R9 third", 64'(r), 64'hA3);
        rd(8'h04, r); check("R9 fourth", 64'(r), 64'hA4);
        rd(8'h04, r); check("R9 push when full dropped", 64'(r), 64'd0);
        check("R8 underflow pulse", 64'(resp_udf_o), 64'd1);
        rd(8'h38, r); check("R8 level stays zero", 64'(r), 64'h4);

        // R5 R6 zero thresholds act as one
        wr(8'h10, 32'h0);
        push(32'hB1);
        check("R6 thr 0 as 1", 64'(resp_ready_o), 64'd1);
        check("R5 thr 0 as 1", 64'(cmd_ready_o), 64'd1);
        rd(8'h04, r); check("R9 single", 64'(r), 64'hB1);
        check("R6 empty after read", 64'(resp_ready_o), 64'd0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule